// File: doc/BRIEF.md
# Byte-Output Leaky Integrator Filter

This block smooths a stream of unsigned 8-bit samples. Each sample goes into a wide running accumulator, and the top byte of that accumulator is the filtered value. On every sample strobe the block takes the current output byte away from the accumulator and then adds the new sample. The result is an exponential moving average with a weight of 1/256. A build option widens the accumulator to 24 bits, which gives a weight of 1/65536 and a much slower response. The update needs only one subtraction and one addition, with no multiplier and no shifter.

The output would otherwise climb slowly up from zero. To avoid that, the first sample after reset is loaded straight into the upper byte, with the lower bits cleared. The output is flagged valid from then on. A strobe updates the accumulator on the same clock edge, so the new output is visible on the next cycle. Generating the sample rate and interfacing to a converter are left to the surrounding logic.

Top module: `byte_leaky_avg`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `avg_out` is 0 and `avg_valid` is 0.
- R2: The first strobe after reset sets `avg_out` equal to that strobe's `smp_data` on the next cycle, and raises `avg_valid` on that same cycle. The lower accumulator bits are cleared.
- R3: Each later strobe replaces the accumulator with (accumulator − zero-extended `avg_out` + zero-extended `smp_data`). `avg_out` shows the upper 8 bits of the result one cycle after the strobe.
- R4: In a cycle without a strobe, `avg_out` and `avg_valid` keep their values.
- R5: After an update, `avg_out` lies between its previous value and the sample that was applied, both bounds included.
- R6: Once seeded with value v, a run of samples all equal to v keeps `avg_out` at exactly v.
- R7: With `WIDE`=1 the accumulator is 24 bits and `avg_out` is still its top 8 bits. Starting from a seed of 0, 256 samples of 255 leave the wide output at 0, while the 16-bit build's output has moved above 100.
- R8: Once `avg_valid` is high it stays high until the next reset.
- R9: The accumulator never wraps. A filter seeded at 255 and fed 255 stays at 255, and one seeded at 0 and fed 0 stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe: take `smp_data` as a new sample |
| smp_data | input | 8 | Unsigned sample value |
| avg_out | output | 8 | Filtered byte (accumulator upper bits) |
| avg_valid | output | 1 | High once the seed sample has been taken |

## Verification
The checker watches several properties on every cycle:
- holding without a strobe;
- the seed load;
- valid staying high once set;
- the output staying between its previous value and the sample applied;
- the absence of wrap in the accumulator arithmetic.

Some results only the bench scenarios can show, because they depend on a long run of history:
- the exact output after long runs of steps, checked against an independent model for both accumulator widths;
- the fixed point under constant input;
- the reset values, including a reset in the middle of a run;
- the much slower response of the wide build.

// File: rtl/lpf_pkg.sv
// Shared sizing helpers for the leaky integrator filter.
// Assumes a sample width no greater than the accumulator width.
package lpf_pkg;
    // Accumulator width for the narrow (x256) or wide (x65536) build.
    function automatic int acc_width(input int data_w, input bit wide);
        return wide ? (3 * data_w) : (2 * data_w);
    endfunction
endpackage

// File: rtl/lpf_prime_ctrl.sv
// Tracks whether the filter has taken its seed sample.
// Splits each strobe into a seed load (first after reset) or a normal update.
// Assumes a synchronous active-low reset.
module lpf_prime_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic seed_take,
    output logic upd_take,
    output logic primed
);
    logic primed_q;

    // Steer the strobe by seed state.
    always_comb begin
        seed_take = stb && !primed_q;
        upd_take  = stb &&  primed_q;
    end

    // Remember that the seed has been loaded until the next reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            primed_q <= 1'b0;
        else if (seed_take)
            primed_q <= 1'b1;
    end

    assign primed = primed_q;
endmodule

// File: rtl/lpf_accum.sv
// Accumulator datapath: seed load or subtract-top/add-sample update.
// Assumes seed_take and upd_take are never high together.
// Wrap cannot occur, since the value stays within [0, 255 * 2^LOW_W + 2^LOW_W - 1].
module lpf_accum #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_take,
    input  logic              upd_take,
    input  logic [DATA_W-1:0] sample,
    output logic [ACC_W-1:0]  acc,
    output logic [DATA_W-1:0] top
);
    localparam int LOW_W = ACC_W - DATA_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] top_ext;
    logic [ACC_W-1:0] smp_ext;
    logic [ACC_W-1:0] seed_val;

    // Upper byte of the current accumulator.
    assign top = acc_q[ACC_W-1 -: DATA_W];

    // Zero-extended operands and seed pattern.
    generate
        if (LOW_W > 0) begin : g_ext
            assign top_ext  = {{LOW_W{1'b0}}, top};
            assign smp_ext  = {{LOW_W{1'b0}}, sample};
            assign seed_val = {sample, {LOW_W{1'b0}}};
        end else begin : g_same
            assign top_ext  = top;
            assign smp_ext  = sample;
            assign seed_val = sample;
        end
    endgenerate

    // Next accumulator value: seed, leaky update, or hold.
    always_comb begin
        if (seed_take)
            acc_d = seed_val;
        else if (upd_take)
            acc_d = acc_q - top_ext + smp_ext;
        else
            acc_d = acc_q;
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/byte_leaky_avg.sv
// Byte-output leaky integrator: exponential average with weight 1/2^(ACC_W-DATA_W).
// The first strobe after reset seeds the output; later strobes update in the same clock.
// Assumes smp_stb is a registered, single-cycle strobe.
module byte_leaky_avg #(
    parameter int DATA_W = 8,
    parameter bit WIDE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] avg_out,
    output logic              avg_valid
);
    import lpf_pkg::*;

    localparam int ACC_W = acc_width(DATA_W, WIDE);

    logic             seed_take;
    logic             upd_take;
    logic             primed;
    logic [ACC_W-1:0] acc_q;

    lpf_prime_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_stb),
        .seed_take (seed_take),
        .upd_take  (upd_take),
        .primed    (primed)
    );

    lpf_accum #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_take (seed_take),
        .upd_take  (upd_take),
        .sample    (smp_data),
        .acc       (acc_q),
        .top       (avg_out)
    );

    assign avg_valid = primed;
endmodule

// File: rtl/lpf_chk.sv
// Assertion checker for byte_leaky_avg, attached by bind below.
// Assumes it sees the top-level ports plus the internal accumulator.
module lpf_chk #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_stb,
    input logic [DATA_W-1:0] smp_data,
    input logic [DATA_W-1:0] avg_out,
    input logic              avg_valid,
    input logic [ACC_W-1:0]  acc
);
    logic [ACC_W+1:0] ext_sum;

    // Update result in two extra bits, to expose any wrap.
    assign ext_sum = {2'b00, acc}
                   - {{(ACC_W-DATA_W+2){1'b0}}, avg_out}
                   + {{(ACC_W-DATA_W+2){1'b0}}, smp_data};

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> ($stable(avg_out) && $stable(avg_valid)));

    p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !avg_valid) |=> (avg_valid && avg_out == $past(smp_data)));

    p_valid_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |=> avg_valid);

    p_bound_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && avg_valid && smp_data >= avg_out)
        |=> (avg_out >= $past(avg_out) && avg_out <= $past(smp_data)));

    p_bound_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && avg_valid && smp_data < avg_out)
        |=> (avg_out <= $past(avg_out) && avg_out >= $past(smp_data)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && avg_valid) |-> (ext_sum[ACC_W+1:ACC_W] == 2'b00));
endmodule

bind byte_leaky_avg lpf_chk #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .smp_data  (smp_data),
    .avg_out   (avg_out),
    .avg_valid (avg_valid),
    .acc       (acc_q)
);

// File: tb/byte_leaky_avg_tb.sv
// Scoreboard bench: the driver pushes expected outputs for both builds, and the monitor pops them.
module byte_leaky_avg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [7:0] smp_data = 8'd0;
    logic [7:0] out_n, out_w;
    logic       val_n, val_w;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp_n;
        logic [7:0] exp_w;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Independent model state.
    logic [15:0] m_n;
    logic [23:0] m_w;
    bit          m_seeded;

    always #4 clk = ~clk;  // 125 MHz

    byte_leaky_avg #(.DATA_W(8), .WIDE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .avg_out(out_n), .avg_valid(val_n));

    byte_leaky_avg #(.DATA_W(8), .WIDE(1'b1)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .avg_out(out_w), .avg_valid(val_w));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: update the model, queue the expectation, pulse the strobe.
    task automatic do_sample(input logic [7:0] s, input string tag);
        exp_t e;
        if (!m_seeded) begin
            m_n = {s, 8'd0};
            m_w = {s, 16'd0};
            m_seeded = 1'b1;
        end else begin
            m_n = m_n - {8'd0, m_n[15:8]} + {8'd0, s};
            m_w = m_w - {16'd0, m_w[23:16]} + {16'd0, s};
        end
        e.exp_n = m_n[15:8];
        e.exp_w = m_w[23:16];
        e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
        smp_stb = 1'b1;
        smp_data = s;
        @(posedge clk); #1;
        smp_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(out_n == 0 && out_w == 0, "R1 out in reset", out_n, 0);
        chk(!val_n && !val_w, "R1 valid in reset", val_n, 0);
        #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        m_n = '0;
        m_w = '0;
        m_seeded = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: one cycle after a strobe, compare both outputs and the valid flags.
    bit due = 1'b0;
    always @(negedge clk) begin
        if (due && q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            chk(out_n == e.exp_n, {e.tag, " narrow"}, out_n, e.exp_n);
            chk(out_w == e.exp_w, {e.tag, " wide R7"}, out_w, e.exp_w);
            chk(val_n && val_w, {e.tag, " valid R8"}, val_n, 1);
        end
        due = smp_stb;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        m_n = '0; m_w = '0; m_seeded = 1'b0;
        do_reset();
        @(negedge clk);
        chk(out_n == 0 && !val_n, "R1 after release", out_n, 0);

        // R2: seed
        do_sample(8'd100, "R2 seed");
        // R6: constant input keeps the value
        for (int i = 0; i < 6; i++) do_sample(8'd100, "R6 const");
        drain();
        chk(out_n == 8'd100 && out_w == 8'd100, "R6 fixed point", out_n, 100);

        // R4: idle cycles hold the output
        held = out_n;
        repeat (12) @(negedge clk);
        chk(out_n == held && val_n, "R4 hold narrow", out_n, held);
        chk(out_w == 8'd100 && val_w, "R4 hold wide", out_w, 100);

        // R3/R5: step up, then down, then alternating
        for (int i = 0; i < 40; i++) do_sample(8'd200, "R3 step up");
        for (int i = 0; i < 300; i++) do_sample(8'd0, "R3 step down");
        for (int i = 0; i < 30; i++) do_sample((i % 2) ? 8'd255 : 8'd3, "R5 alternate");
        drain();

        // R1/R8: reset in mid-run clears valid, then R9 at full scale
        do_reset();
        @(negedge clk);
        chk(!val_n && !val_w, "R8 valid cleared by reset", val_n, 0);
        do_sample(8'd255, "R2 reseed");
        for (int i = 0; i < 20; i++) do_sample(8'd255, "R9 full scale");
        drain();
        chk(out_n == 8'd255 && out_w == 8'd255, "R9 no wrap high", out_n, 255);

        // R9 low end, then R7 step response speed
        do_reset();
        do_sample(8'd0, "R2 seed zero");
        for (int i = 0; i < 10; i++) do_sample(8'd0, "R9 zero");
        drain();
        chk(out_n == 0 && out_w == 0, "R9 no wrap low", out_n, 0);
        for (int i = 0; i < 256; i++) do_sample(8'd255, "R7 step");
        drain();
        chk(out_w == 8'd0, "R7 wide slow", out_w, 0);
        chk(out_n > 8'd100, "R7 narrow faster", out_n, 101);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule